// File: doc/BRIEF.md
# Bit-Serial Link Master Engine

This block is the master end of a two-wire serial link. One wire is a clock that the master always drives. The other is a data wire that both ends use in turn. A host loads a 24-bit command, two 32-bit payload words and two delay counts, then pulses `start`. The block runs one of three operations. The first sends a request frame and captures the slave's reply. The second sends a link break sequence. The third emits a number of idle clocks.

The block drives the link clock, the data output, the data output enable and a transceiver direction line. It samples the incoming data. Both directions invert the data: a logical 1 appears on the wire as a low level, and the idle wire level is high.

Each link clock period is one bit slot. A slot is a low phase followed by a high phase, and each phase lasts `half_per` system clocks. The block changes output data at the start of a slot, when the clock falls. It samples input data on the system clock edge where the link clock rises.

When the operation ends, the block returns a status code, the response tag, the response data word and the response check nibble. These values stay unchanged until the next command is accepted. Computing or checking the check nibble is outside this block.

Top module: `serial_link_master`

## Requirements
- R1: Logical payload bits are driven inverted (logical 1 gives `sdo`=0), and received bits are inverted after sampling. Every idle or padding slot drives `sdo`=1.
- R2: `cmd[7:0]`=8'h01 starts a request frame. The first slot drives `sdo`=0. Next come N=`cmd[15:8]` payload slots, most significant bit first. Bit i comes from `pay0[31-i]` for i<32 and from `pay1[63-i]` for 32<=i<64. Logical bits past 64 are 0, so the wire stays high.
- R3: After the payload, `echo_dly` idle slots follow with `sdo_oe`=1. From the next slot onward, `sdo_oe` and `xcvr_tx` stay 0 up to and including the last send-delay slot.
- R4: After the echo slots, the block hunts for the reply start bit for at most 1000 slots. A start bit is `sdi` sampled low. If none is found, the status is 2 (timeout), no reply field is captured, and the tag, data and check outputs read 0.
- R5: After the start bit, the block captures a 4-bit tag, first bit into the MSB. A data field follows only when tag[1:0]==0 and `cmd[23:16]`!=0. Its length is min(`cmd[23:16]`,32) bits, right-aligned, with the upper bits 0. A 4-bit check field always ends the reply.
- R6: Every frame, whether complete or timed out, ends with `send_dly` idle slots. After the frame, `sdo_oe`=1, `xcvr_tx`=1 and `sdo`=1.
- R7: `cmd[7:0]`=8'h02 sends 50 high slots, then 256 low slots, then 16000 high slots, and finishes with status 1.
- R8: `cmd[7:0]`=8'h03 sends `cmd[15:8]` high slots with `sdo_oe`=1 and finishes with status 1. A count of 0 finishes at once with no clocks.
- R9: Any other code in `cmd[7:0]` finishes with status 3 and no link clock. `busy` never rises and `done` pulses in the next cycle.
- R10: While the block is idle, `lclk` toggles with the slot timing when `cont_en`=1. When `cont_en`=0, `lclk` stays high.
- R11: The low phase and the high phase each last `half_per` system clocks, and a value of 0 counts as 1.
- R12: `start` is accepted only while the block is idle. `busy` stays high from the cycle after acceptance until `done`, and `done` is a one-cycle pulse. The status (0 none, 1 complete, 2 timeout, 3 invalid) and all results clear to 0 on acceptance, then hold until the next accepted command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command request pulse |
| cmd | input | 24 | Opcode [7:0], bit/clock count [15:8], reply data length [23:16] |
| pay0 | input | 32 | First payload word |
| pay1 | input | 32 | Second payload word |
| echo_dly | input | 8 | Turnaround idle slots after the payload |
| send_dly | input | 8 | Idle slots that close every frame |
| half_per | input | HW | System clocks per link clock phase |
| cont_en | input | 1 | Keep the link clock running while idle |
| sdi | input | 1 | Data wire, input side |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | Result code |
| rsp_tag | output | 4 | Captured reply tag |
| rsp_data | output | 32 | Captured reply data |
| rsp_crc | output | 4 | Captured reply check nibble |
| lclk | output | 1 | Link clock |
| sdo | output | 1 | Data wire, output side |
| sdo_oe | output | 1 | Data wire output enable |
| xcvr_tx | output | 1 | Transceiver direction, 1 = toward the slave |

## Verification
A wrong internal count shows at the ports at once as a different number of `lclk` rising edges between `start` and `done`. The bench compares this count exactly, frame by frame, so a single extra or missing slot in the payload, echo, hunt, reply fields or send delay is caught. A sequencing or shift fault appears within the same frame, either as a wrong bit in the slot-by-slot record of `sdo` and `sdo_oe` or as a wrong captured field. The timing counter is checked by counting low system cycles against rising edges, which exposes a wrong phase length after the first slot.

// File: rtl/slm_pkg.sv
package slm_pkg;

  typedef enum logic [1:0] {
    STS_NONE = 2'd0,
    STS_DONE = 2'd1,
    STS_TMO  = 2'd2,
    STS_BAD  = 2'd3
  } sts_e;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_TX, S_ECHO, S_HUNT, S_TAG, S_DATA,
    S_CRC, S_SDLY, S_PRE, S_BRK, S_POST, S_PAD
  } st_e;

  typedef enum logic [1:0] {
    FLD_NONE, FLD_TAG, FLD_DATA, FLD_CRC
  } fld_e;

  localparam logic [7:0] OP_FRAME = 8'h01;
  localparam logic [7:0] OP_BREAK = 8'h02;
  localparam logic [7:0] OP_PAD   = 8'h03;

endpackage

// File: rtl/slm_clkgen.sv
module slm_clkgen #(
  parameter int HW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          clr,
  input  logic [HW-1:0] half,
  output logic          lclk,
  output logic          smp,
  output logic          last
);
  localparam int CW = HW + 1;

  logic [CW-1:0] tcnt;
  logic [CW-1:0] ph;

  // a programmed phase of zero is treated as one system clock
  function automatic logic [CW-1:0] phase_len(input logic [HW-1:0] x);
    return (x == '0) ? CW'(1) : CW'(x);
  endfunction

  assign ph   = phase_len(half);
  assign smp  = run && (tcnt == ph - CW'(1));
  assign last = run && (tcnt >= (ph << 1) - CW'(1));
  assign lclk = !run || (tcnt >= ph);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  tcnt <= '0;
    else if (clr || !run || last) tcnt <= '0;
    else                         tcnt <= tcnt + CW'(1);
  end

  AST_SAMPLE_THEN_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (smp && !clr && !last) |=> lclk); // R11

endmodule

// File: rtl/slm_rxcap.sv
module slm_rxcap
  import slm_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          smp,
  input  fld_e          fld,
  input  logic          sdi,
  output logic          lo_seen,
  output logic [3:0]    tag,
  output logic [DW-1:0] data,
  output logic [3:0]    crc
);
  logic bit_in;
  assign bit_in = ~sdi;  // wire low is a logical one

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_seen <= 1'b0;
      tag     <= '0;
      data    <= '0;
      crc     <= '0;
    end else if (clr) begin
      lo_seen <= 1'b0;
      tag     <= '0;
      data    <= '0;
      crc     <= '0;
    end else if (smp) begin
      lo_seen <= bit_in;
      case (fld)
        FLD_TAG:  tag  <= {tag[2:0], bit_in};
        FLD_DATA: data <= {data[DW-2:0], bit_in};
        FLD_CRC:  crc  <= {crc[2:0], bit_in};
        default:  ;
      endcase
    end
  end

  AST_FIELDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp && !clr) |=> ($stable(tag) && $stable(data) && $stable(crc))); // R12

endmodule

// File: rtl/serial_link_master.sv
module serial_link_master
  import slm_pkg::*;
#(
  parameter int HW       = 4,
  parameter int CNT_W    = 16,
  parameter int PRE_N    = 50,
  parameter int BRK_N    = 256,
  parameter int POST_N   = 16000,
  parameter int HUNT_MAX = 1000,
  parameter int DMAX     = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [23:0]     cmd,
  input  logic [31:0]     pay0,
  input  logic [31:0]     pay1,
  input  logic [7:0]      echo_dly,
  input  logic [7:0]      send_dly,
  input  logic [HW-1:0]   half_per,
  input  logic            cont_en,
  input  logic            sdi,
  output logic            busy,
  output logic            done,
  output logic [1:0]      status,
  output logic [3:0]      rsp_tag,
  output logic [DMAX-1:0] rsp_data,
  output logic [3:0]      rsp_crc,
  output logic            lclk,
  output logic            sdo,
  output logic            sdo_oe,
  output logic            xcvr_tx
);
  localparam logic [CNT_W-1:0] PRE_LAST  = CNT_W'(PRE_N - 1);
  localparam logic [CNT_W-1:0] BRK_LAST  = CNT_W'(BRK_N - 1);
  localparam logic [CNT_W-1:0] POST_LAST = CNT_W'(POST_N - 1);
  localparam logic [CNT_W-1:0] HUNT_LAST = CNT_W'(HUNT_MAX - 1);
  localparam logic [CNT_W-1:0] NIB_LAST  = CNT_W'(3);

  st_e              st, st_n;
  sts_e             pend, pend_n, sts_q, fin_sts;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic [63:0]      tx_sh;
  logic [7:0]       nbits, dlen, echo_q, sdly_q;
  logic             fin, go, run, smp, last, lo_seen, cnt_zero, rx_dir;
  fld_e             fld;

  // reply data length, clamped to the capture register width
  function automatic logic [7:0] data_bits(input logic [7:0] n);
    return (n > 8'(DMAX)) ? 8'(DMAX) : n;
  endfunction

  assign go       = start && (st == S_IDLE);
  assign run      = (st != S_IDLE) || cont_en;
  assign cnt_zero = (cnt == '0);
  assign rx_dir   = (st == S_HUNT) || (st == S_TAG) || (st == S_DATA) ||
                    (st == S_CRC)  || (st == S_SDLY);

  always_comb begin
    case (st)
      S_TAG:   fld = FLD_TAG;
      S_DATA:  fld = FLD_DATA;
      S_CRC:   fld = FLD_CRC;
      default: fld = FLD_NONE;
    endcase
  end

  slm_clkgen #(.HW(HW)) i_clkgen (
    .clk(clk), .rst_n(rst_n), .run(run), .clr(go), .half(half_per),
    .lclk(lclk), .smp(smp), .last(last)
  );

  slm_rxcap #(.DW(DMAX)) i_rxcap (
    .clk(clk), .rst_n(rst_n), .clr(go), .smp(smp), .fld(fld), .sdi(sdi),
    .lo_seen(lo_seen), .tag(rsp_tag), .data(rsp_data), .crc(rsp_crc)
  );

  always_comb begin
    st_n    = st;
    cnt_n   = cnt;
    pend_n  = pend;
    fin     = 1'b0;
    fin_sts = pend;
    if (st == S_IDLE) begin
      if (start) begin
        case (cmd[7:0])
          OP_FRAME: st_n = S_START;
          OP_BREAK: begin st_n = S_PRE; cnt_n = PRE_LAST; end
          OP_PAD: begin
            if (cmd[15:8] == 8'd0) begin fin = 1'b1; fin_sts = STS_DONE; end
            else begin st_n = S_PAD; cnt_n = CNT_W'(cmd[15:8] - 8'd1); end
          end
          default: begin fin = 1'b1; fin_sts = STS_BAD; end
        endcase
      end
    end else if (last) begin
      case (st)
        S_START, S_TX: begin
          if ((st == S_START) ? (nbits == 8'd0) : cnt_zero) begin
            if (echo_q == 8'd0) begin st_n = S_HUNT; cnt_n = '0; end
            else begin st_n = S_ECHO; cnt_n = CNT_W'(echo_q - 8'd1); end
          end else if (st == S_START) begin
            st_n = S_TX; cnt_n = CNT_W'(nbits - 8'd1);
          end else cnt_n = cnt - CNT_W'(1);
        end
        S_ECHO: begin
          if (cnt_zero) begin st_n = S_HUNT; cnt_n = '0; end
          else cnt_n = cnt - CNT_W'(1);
        end
        S_HUNT, S_CRC: begin
          if (st == S_HUNT && lo_seen) begin
            st_n = S_TAG; cnt_n = NIB_LAST;
          end else if (st == S_HUNT && cnt != HUNT_LAST) begin
            cnt_n = cnt + CNT_W'(1);
          end else if (st == S_CRC && !cnt_zero) begin
            cnt_n = cnt - CNT_W'(1);
          end else begin
            pend_n = (st == S_HUNT) ? STS_TMO : STS_DONE;
            if (sdly_q == 8'd0) begin fin = 1'b1; fin_sts = pend_n; end
            else begin st_n = S_SDLY; cnt_n = CNT_W'(sdly_q - 8'd1); end
          end
        end
        S_TAG: begin
          if (!cnt_zero) cnt_n = cnt - CNT_W'(1);
          else if (rsp_tag[1:0] == 2'b00 && dlen != 8'd0) begin
            st_n = S_DATA; cnt_n = CNT_W'(data_bits(dlen) - 8'd1);
          end else begin st_n = S_CRC; cnt_n = NIB_LAST; end
        end
        S_DATA: begin
          if (cnt_zero) begin st_n = S_CRC; cnt_n = NIB_LAST; end
          else cnt_n = cnt - CNT_W'(1);
        end
        S_PRE: begin
          if (cnt_zero) begin st_n = S_BRK; cnt_n = BRK_LAST; end
          else cnt_n = cnt - CNT_W'(1);
        end
        S_BRK: begin
          if (cnt_zero) begin st_n = S_POST; cnt_n = POST_LAST; end
          else cnt_n = cnt - CNT_W'(1);
        end
        S_POST, S_PAD: begin
          if (cnt_zero) begin fin = 1'b1; fin_sts = STS_DONE; end
          else cnt_n = cnt - CNT_W'(1);
        end
        S_SDLY: begin
          if (cnt_zero) fin = 1'b1;
          else cnt_n = cnt - CNT_W'(1);
        end
        default: ;
      endcase
    end
    if (fin) st_n = S_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      pend   <= STS_NONE;
      sts_q  <= STS_NONE;
      done   <= 1'b0;
      tx_sh  <= '0;
      nbits  <= '0;
      dlen   <= '0;
      echo_q <= '0;
      sdly_q <= '0;
    end else begin
      st   <= st_n;
      cnt  <= cnt_n;
      pend <= pend_n;
      done <= fin;
      if (go) begin
        sts_q  <= STS_NONE;
        tx_sh  <= {pay0, pay1};
        nbits  <= cmd[15:8];
        dlen   <= cmd[23:16];
        echo_q <= echo_dly;
        sdly_q <= send_dly;
      end else if (st == S_TX && last) begin
        tx_sh <= {tx_sh[62:0], 1'b0};
      end
      if (fin) sts_q <= fin_sts;
    end
  end

  always_comb begin
    case (st)
      S_START, S_BRK: sdo = 1'b0;
      S_TX:           sdo = ~tx_sh[63];
      default:        sdo = 1'b1;
    endcase
  end

  assign sdo_oe  = !rx_dir;
  assign xcvr_tx = !rx_dir;
  assign busy    = (st != S_IDLE);
  assign status  = sts_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done); // R12
  AST_HUNT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HUNT) |-> (cnt <= HUNT_LAST)); // R4
  AST_TAG_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TAG && $past(st) == S_HUNT) |-> $past(lo_seen)); // R4
  AST_RESULTS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !start) |=> ($stable(rsp_data) && $stable(rsp_tag) && $stable(rsp_crc) && $stable(status))); // R12
  AST_LINE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !cont_en) |-> (lclk && sdo && sdo_oe)); // R10

endmodule

// File: tb/test_serial_link_master.sv
module test_serial_link_master;
  localparam int CLK_P = 10;
  localparam int MAXR  = 17000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] cmd = '0;
  logic [31:0] pay0 = '0, pay1 = '0;
  logic [7:0]  echo_dly = '0, send_dly = '0;
  logic [3:0]  half_per = 4'd1;
  logic        cont_en = 1'b0;
  logic        sdi = 1'b1;
  logic        busy, done, lclk, sdo, sdo_oe, xcvr_tx;
  logic [1:0]  status;
  logic [3:0]  rsp_tag, rsp_crc;
  logic [31:0] rsp_data;

  serial_link_master i_serial_link_master (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .pay0(pay0), .pay1(pay1),
    .echo_dly(echo_dly), .send_dly(send_dly), .half_per(half_per), .cont_en(cont_en),
    .sdi(sdi), .busy(busy), .done(done), .status(status), .rsp_tag(rsp_tag),
    .rsp_data(rsp_data), .rsp_crc(rsp_crc), .lclk(lclk), .sdo(sdo),
    .sdo_oe(sdo_oe), .xcvr_tx(xcvr_tx)
  );

  always #(CLK_P/2) clk = ~clk;

  int nvec = 0, nfail = 0;
  logic resp [MAXR];
  logic wdo [MAXR];
  logic woe [MAXR];
  logic wxt [MAXR];
  int nr = 0, nf = 0, nlow = 0, ndone = 0;
  bit arm = 1'b0, arm_seen = 1'b0;
  logic lprev = 1'b1;

  // slot recorder and slave model: rising edges record the wire, falls set sdi
  always @(negedge clk) begin
    if (arm != arm_seen) begin
      nr = 0; nf = 0; nlow = 0; ndone = 0; arm_seen = arm;
    end
    if (lclk && !lprev) begin
      if (nr < MAXR) begin wdo[nr] = sdo; woe[nr] = sdo_oe; wxt[nr] = xcvr_tx; end
      nr++;
    end
    if (!lclk && lprev) begin
      sdi = (nf < MAXR) ? resp[nf] : 1'b1;
      nf++;
    end
    if (!lclk) nlow++;
    if (done) ndone++;
    lprev = lclk;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic fill_idle();
    for (int i = 0; i < MAXR; i++) resp[i] = 1'b1;
  endtask

  task automatic issue(input logic [23:0] c);
    @(negedge clk); arm = ~arm; cmd = c;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done();
    int c = 0;
    while (!done && c < 60000) begin @(negedge clk); c++; end
    chk(done, "R12", "done pulse reached", done, 1);
    repeat (3) @(negedge clk);
  endtask

  function automatic logic pbit(input logic [31:0] p0, input logic [31:0] p1, input int i);
    if (i < 32) return p0[31-i];
    if (i < 64) return p1[63-i];
    return 1'b0;
  endfunction

  task automatic do_frame(input int nb, input int dl, input int ech, input int sd,
                          input int h, input int lag, input logic [3:0] tg,
                          input logic [31:0] dv, input logic [3:0] cr,
                          input logic [31:0] p0, input logic [31:0] p1, input bit poke);
    int L, nd, hh, idx, exp_slots, bad_d, bad_o;
    logic [31:0] exp_data;
    L  = 1 + nb + ech;
    hh = (h == 0) ? 1 : h;
    nd = (lag < 1000 && tg[1:0] == 2'b00 && dl != 0) ? ((dl > 32) ? 32 : dl) : 0;
    fill_idle();
    if (lag < 1000) begin
      idx = L + lag;
      resp[idx] = 1'b0; idx++;
      for (int k = 0; k < 4; k++) begin resp[idx] = ~tg[3-k]; idx++; end
      for (int k = 0; k < nd; k++) begin resp[idx] = ~dv[nd-1-k]; idx++; end
      for (int k = 0; k < 4; k++) begin resp[idx] = ~cr[3-k]; idx++; end
      exp_slots = L + lag + 1 + 4 + nd + 4 + sd;
    end else exp_slots = L + 1000 + sd;
    if (nd == 0)       exp_data = 32'h0;
    else if (nd == 32) exp_data = dv;
    else               exp_data = dv & ((32'h1 << nd) - 32'h1);
    pay0 = p0; pay1 = p1; echo_dly = 8'(ech); send_dly = 8'(sd); half_per = 4'(h);
    issue({8'(dl), 8'(nb), 8'h01});
    if (poke) begin
      repeat (4) @(negedge clk);
      cmd = 24'h0000FF; start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    wait_done();
    chk(nr == exp_slots, "R2", "frame slot count", nr, exp_slots);
    chk(nlow == hh * nr, "R11", "low system cycles", nlow, hh * nr);
    chk(ndone == 1, "R12", "done cycles", ndone, 1);
    chk(status == ((lag < 1000) ? 2'd1 : 2'd2), (lag < 1000) ? "R5" : "R4", "status",
        status, (lag < 1000) ? 1 : 2);
    bad_d = 0; bad_o = 0;
    for (int i = 0; i < nr && i < MAXR; i++) begin
      if (i == 0)       begin if (wdo[i] !== 1'b0) bad_d++; end
      else if (i <= nb) begin if (wdo[i] !== ~pbit(p0, p1, i-1)) bad_d++; end
      else if (i < L)   begin if (wdo[i] !== 1'b1) bad_d++; end
      if (i < L) begin if (woe[i] !== 1'b1 || wxt[i] !== 1'b1) bad_o++; end
      else       begin if (woe[i] !== 1'b0 || wxt[i] !== 1'b0) bad_o++; end
    end
    chk(bad_d == 0, "R1", "inverted payload slots wrong", bad_d, 0);
    chk(bad_o == 0, "R3", "direction slots wrong", bad_o, 0);
    chk(sdo_oe && xcvr_tx && sdo && lclk, "R6", "line after frame",
        {sdo_oe, xcvr_tx, sdo, lclk}, 15);
    chk(rsp_tag == ((lag < 1000) ? tg : 4'h0), "R5", "tag", rsp_tag, (lag < 1000) ? tg : 0);
    chk(rsp_data == exp_data, "R5", "data", rsp_data, exp_data);
    chk(rsp_crc == ((lag < 1000) ? cr : 4'h0), "R5", "crc", rsp_crc, (lag < 1000) ? cr : 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    nfail++;
    $display("FAIL R12 watchdog: actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    int zc, zfirst, zlast, bad;
    logic [3:0] tgl [5];
    int dll [5];
    int nbl [5];
    tgl[0] = 4'h0; tgl[1] = 4'hC; tgl[2] = 4'h0; tgl[3] = 4'h2; tgl[4] = 4'h4;
    dll[0] = 8;  dll[1] = 8;  dll[2] = 32; dll[3] = 40; dll[4] = 0;
    nbl[0] = 1;  nbl[1] = 7;  nbl[2] = 32; nbl[3] = 33; nbl[4] = 64;
    fill_idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && status == 2'd0, "R12", "reset status", {busy, done, status}, 0);
    chk(lclk && sdo && sdo_oe && xcvr_tx && rsp_data == 0, "R10", "reset line",
        {lclk, sdo, sdo_oe, xcvr_tx}, 15);

    // sweep: phase lengths x payload lengths x reply shapes
    for (int h = 1; h <= 3; h++) begin
      for (int k = 0; k < 5; k++) begin
        do_frame(nbl[k], dll[(k+h)%5], (k+h)%4, k, h, 3*k + h, tgl[(k+h)%5],
                 32'hA5C3_0F96 ^ (32'h1111_1111 * k), 4'(k*3 + h),
                 32'h8000_0001 ^ (32'h0F0F_0F0F * h), 32'hDEAD_BEEF + k, (k == 2));
      end
    end
    do_frame(70, 0, 0, 2, 0, 0, 4'h1, 32'h0, 4'hE, 32'h1234_5678, 32'h9ABC_DEF0, 1'b0);
    // no reply start: hunt window expires
    do_frame(3, 8, 1, 2, 1, 1000, 4'h0, 32'h0, 4'h0, 32'hF000_0000, 32'h0, 1'b0);

    // break sequence
    half_per = 4'd1; fill_idle();
    issue(24'h000002);
    wait_done();
    chk(nr == 16306, "R7", "break slots", nr, 16306);
    zc = 0; zfirst = -1; zlast = -1; bad = 0;
    for (int i = 0; i < nr && i < MAXR; i++) begin
      if (wdo[i] === 1'b0) begin zc++; if (zfirst < 0) zfirst = i; zlast = i; end
      if (woe[i] !== 1'b1) bad++;
    end
    chk(zc == 256, "R7", "break low slots", zc, 256);
    chk(zfirst == 50 && zlast == 305, "R7", "break low start", zfirst, 50);
    chk(bad == 0 && status == 2'd1, "R7", "break status", status, 1);

    // invalid opcode, then status clears on the next accepted command
    issue(24'h00007E);
    chk(done && !busy, "R9", "invalid finishes next cycle", {done, busy}, 2);
    @(negedge clk);
    chk(status == 2'd3 && nr == 0, "R9", "invalid status", status, 3);
    issue(24'h001403);
    @(negedge clk);
    chk(status == 2'd0 && busy, "R12", "status cleared while busy", status, 0);
    wait_done();
    chk(nr == 20 && status == 2'd1, "R8", "idle clock count", nr, 20);
    bad = 0;
    for (int i = 0; i < nr && i < MAXR; i++) if (wdo[i] !== 1'b1 || woe[i] !== 1'b1) bad++;
    chk(bad == 0, "R8", "idle clocks high", bad, 0);
    issue(24'h000003);
    chk(done && !busy, "R8", "zero count immediate", {done, busy}, 2);
    @(negedge clk);
    chk(nr == 0 && status == 2'd1, "R8", "zero count clocks", nr, 0);

    // continuous idle clock
    half_per = 4'd2; cont_en = 1'b1;
    @(negedge clk); arm = ~arm;
    repeat (100) @(negedge clk);
    chk(nr >= 24 && nr <= 26, "R10", "free-running rises", nr, 25);
    cont_en = 1'b0;
    repeat (6) @(negedge clk); arm = ~arm;
    repeat (40) @(negedge clk);
    chk(nr == 0 && lclk, "R10", "clock parked high", nr, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule